// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the bus-side protocol engine of a 2048-byte serial EEPROM on a two-wire bus. It receives SCL and SDA levels that are already synchronised to the system clock. It also receives one-cycle start and stop strobes from a separate condition detector. It controls SDA only through an active-high pull-down enable. It finds SCL edges itself, shifts bytes in on rising edges, and changes its own SDA bit only after falling edges.

A transfer opens with a device byte. Its upper nibble must carry the fixed tag 1010, its bits 3:1 supply word-address bits 10:8, and bit 0 chooses read (1) or write (0). In a write, the next byte is the low eight bits of the word address. Each byte after that is handed to an external page buffer with its target address, and the address then advances inside a 16-byte page. A stop that follows at least one data byte emits a commit pulse for the nonvolatile write timer.

A read streams bytes from a combinational memory port, starting at the current address, and moves through the whole array while the master keeps acknowledging. The random-read sequence works like this: write the address without data, send a repeated start, then issue a read. While the external commit is busy, no device byte is acknowledged, so the master can poll for completion.

Top module: `ee2w_slave`

## Requirements
- R1: While reset is high and in the cycle after it, `sda_pull`, `wbuf_we` and `commit_go` are 0 and `mem_raddr` is 0.
- R2: A device byte whose bits 7:4 differ from 1010 is not acknowledged. The rest of the transfer up to the next start is ignored, so `sda_pull` stays 0.
- R3: Every accepted byte is acknowledged with `sda_pull` = 1 from the SCL fall after its eighth bit until the SCL fall that ends the ninth clock. `sda_pull` never changes while SCL stays high, except at a start or stop strobe.
- R4: Device-byte bits 3:1 become address bits 10:8. Bit 0 = 1 selects a read and bit 0 = 0 selects a write.
- R5: In a write, the second byte sets address bits 7:0. Each later byte is acknowledged and raises `wbuf_we` for one cycle with `wbuf_addr` = current address and `wbuf_data` = the byte. The pulse comes two clock cycles after the SCL rise of the byte's last bit.
- R6: After each data byte only address bits 3:0 increment, wrapping from 0xF to 0x0. Bits 10:4 are held.
- R7: While `commit_busy` is 1, a device byte with a matching tag is not acknowledged.
- R8: A stop after at least one data byte of the current write gives exactly one `commit_go` pulse in the cycle after the stop strobe. A stop with no data byte gives none.
- R9: A read drives the byte at `mem_raddr` MSB first, and each bit changes after an SCL fall. A master acknowledge (SDA low on the ninth clock) advances the full 11-bit address, wrapping 0x7FF to 0x000. A master non-acknowledge releases SDA for the rest of the transfer.
- R10: A start strobe at any point, including in the middle of a byte, abandons the transfer without a buffer write or commit and begins a new device byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA bus level |
| start_strb | input | 1 | One-cycle start-condition strobe |
| stop_strb | input | 1 | One-cycle stop-condition strobe |
| commit_busy | input | 1 | Nonvolatile write cycle in progress |
| mem_rdata | input | 8 | Memory byte at `mem_raddr` (combinational) |
| sda_pull | output | 1 | Pull SDA low when 1 |
| mem_raddr | output | 11 | Current word address for reads |
| wbuf_we | output | 1 | Page-buffer byte write strobe |
| wbuf_addr | output | 11 | Page-buffer byte address |
| wbuf_data | output | 8 | Page-buffer byte data |
| commit_go | output | 1 | Start the internally timed write cycle |

## Verification
Most internal faults show up at the ports within one byte. A wrong bit count or a wrong state moves the acknowledge off the ninth clock, so the master sees a missing or misplaced zero on that same clock. A wrong address register shows up as a wrong `wbuf_addr` on the next data byte, or as wrong read data on the next byte read. The page and linear wrap rules are only visible at the 0xF and 0x7FF boundaries, so those are driven directly. A lost write-session flag shows up only at the following stop, as a missing or extra `commit_go`.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

    localparam logic [3:0] DEV_TAG = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WLO,
        S_WLO_ACK,
        S_WDAT,
        S_WDAT_ACK,
        S_RD,
        S_RACK,
        S_RNEXT
    } sl_state_e;

    // shift-register controls, one-cycle strobes
    typedef struct packed {
        logic cap;    // shift in the sampled SDA bit and count it
        logic count;  // count an SCL rise without shifting
        logic adv;    // shift out toward the next transmit bit
        logic load;   // parallel load for transmit
        logic clr;    // clear the bit counter
    } sh_ctl_t;

    // address-register controls
    typedef struct packed {
        logic set_hi;
        logic set_lo;
        logic inc_page;
        logic inc_lin;
    } ad_ctl_t;

endpackage

// File: rtl/ee2w_edge.sv
module ee2w_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= 1'b1;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
    assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/ee2w_shreg.sv
module ee2w_shreg
    import ee2w_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = $clog2(W + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  sh_ctl_t        ctl,
    input  logic           din,
    input  logic [W-2:0]   pdata,
    output logic [W-2:0]   q,
    output logic [CW-1:0]  cnt
);
    // W-1 stored bits: on receive the live SDA bit completes the byte,
    // on transmit the MSB goes straight to the pull register.
    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            cnt <= '0;
        end else if (ctl.clr) begin
            cnt <= '0;
        end else if (ctl.load) begin
            q   <= pdata;
            cnt <= '0;
        end else begin
            if (ctl.cap)      q <= {q[W-3:0], din};
            else if (ctl.adv) q <= {q[W-3:0], 1'b0};
            if (ctl.cap || ctl.count) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ee2w_addr_ctr.sv
module ee2w_addr_ctr
    import ee2w_pkg::*;
#(
    parameter int AW = 11,
    parameter int PW = 4,
    parameter int DW = 8,
    parameter int HW = AW - DW
) (
    input  logic           clk,
    input  logic           rst,
    input  ad_ctl_t        ctl,
    input  logic [HW-1:0]  hi,
    input  logic [DW-1:0]  lo,
    output logic [AW-1:0]  addr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
        end else if (ctl.set_hi) begin
            addr[AW-1:DW] <= hi;
        end else if (ctl.set_lo) begin
            addr[DW-1:0] <= lo;
        end else if (ctl.inc_page) begin
            addr[PW-1:0] <= addr[PW-1:0] + 1'b1;
        end else if (ctl.inc_lin) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/ee2w_fsm.sv
module ee2w_fsm
    import ee2w_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8,
    parameter int CW = $clog2(DW + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rise,
    input  logic           fall,
    input  logic           start,
    input  logic           stop,
    input  logic           sda,
    input  logic           busy,
    input  logic [CW-1:0]  cnt,
    input  logic [DW-1:0]  rx_byte,
    input  logic           tx_next,
    input  logic           mem_msb,
    input  logic [AW-1:0]  addr,
    output sh_ctl_t        sh,
    output ad_ctl_t        ad,
    output logic           pull,
    output logic           wb_we,
    output logic [AW-1:0]  wb_addr,
    output logic [DW-1:0]  wb_data,
    output logic           commit
);
    sl_state_e st, ns;
    logic pull_n, half, half_n, rnw, rnw_n, wrote, wrote_n, we_n, commit_n;
    logic last_rx, last_tx, tag_hit;

    assign last_rx = (cnt == CW'(DW - 1));
    assign last_tx = (cnt == CW'(DW));
    assign tag_hit = (rx_byte[DW-1 -: 4] == DEV_TAG);

    always_comb begin
        ns       = st;
        pull_n   = pull;
        half_n   = half;
        rnw_n    = rnw;
        wrote_n  = wrote;
        we_n     = 1'b0;
        commit_n = 1'b0;
        sh       = '0;
        ad       = '0;
        if (start) begin
            ns      = S_DEV;
            pull_n  = 1'b0;
            half_n  = 1'b0;
            wrote_n = 1'b0;
            sh.clr  = 1'b1;
        end else if (stop) begin
            ns       = S_IDLE;
            pull_n   = 1'b0;
            half_n   = 1'b0;
            commit_n = wrote;
            wrote_n  = 1'b0;
        end else begin
            case (st)
                S_DEV, S_WLO, S_WDAT: begin
                    if (rise) begin
                        sh.cap = 1'b1;
                        if (last_rx) begin
                            if (st == S_DEV) begin
                                if (tag_hit && !busy) begin
                                    ad.set_hi = 1'b1;
                                    rnw_n     = rx_byte[0];
                                    ns        = S_DEV_ACK;
                                end else begin
                                    ns = S_IDLE;
                                end
                            end else if (st == S_WLO) begin
                                ad.set_lo = 1'b1;
                                ns        = S_WLO_ACK;
                            end else begin
                                we_n        = 1'b1;
                                ad.inc_page = 1'b1;
                                wrote_n     = 1'b1;
                                ns          = S_WDAT_ACK;
                            end
                        end
                    end
                end
                S_DEV_ACK, S_WLO_ACK, S_WDAT_ACK: begin
                    if (fall) begin
                        if (!half) begin
                            pull_n = 1'b1;
                            half_n = 1'b1;
                        end else begin
                            half_n = 1'b0;
                            pull_n = 1'b0;
                            if (st == S_DEV_ACK && rnw) begin
                                sh.load = 1'b1;
                                pull_n  = ~mem_msb;
                                ns      = S_RD;
                            end else begin
                                sh.clr = 1'b1;
                                ns     = (st == S_DEV_ACK) ? S_WLO : S_WDAT;
                            end
                        end
                    end
                end
                S_RD: begin
                    if (rise) begin
                        sh.count = 1'b1;
                    end else if (fall) begin
                        if (last_tx) begin
                            pull_n = 1'b0;
                            ns     = S_RACK;
                        end else begin
                            sh.adv = 1'b1;
                            pull_n = ~tx_next;
                        end
                    end
                end
                S_RACK: begin
                    if (rise) begin
                        if (!sda) begin
                            ad.inc_lin = 1'b1;
                            ns         = S_RNEXT;
                        end else begin
                            ns = S_IDLE;
                        end
                    end
                end
                S_RNEXT: begin
                    if (fall) begin
                        sh.load = 1'b1;
                        pull_n  = ~mem_msb;
                        ns      = S_RD;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            pull    <= 1'b0;
            half    <= 1'b0;
            rnw     <= 1'b0;
            wrote   <= 1'b0;
            wb_we   <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
            commit  <= 1'b0;
        end else begin
            st     <= ns;
            pull   <= pull_n;
            half   <= half_n;
            rnw    <= rnw_n;
            wrote  <= wrote_n;
            wb_we  <= we_n;
            commit <= commit_n;
            if (we_n) begin
                wb_addr <= addr;
                wb_data <= rx_byte;
            end
        end
    end
endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
    import ee2w_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              start_strb,
    input  logic              stop_strb,
    input  logic              commit_busy,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic              wbuf_we,
    output logic [ADDR_W-1:0] wbuf_addr,
    output logic [DATA_W-1:0] wbuf_data,
    output logic              commit_go
);
    localparam int HI_W  = ADDR_W - DATA_W;
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic              scl_rise, scl_fall;
    sh_ctl_t           sh_ctl;
    ad_ctl_t           ad_ctl;
    logic [DATA_W-2:0] sh_q;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] rx_byte;
    logic [ADDR_W-1:0] addr_q;

    assign rx_byte   = {sh_q, sda_in};
    assign mem_raddr = addr_q;

    ee2w_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (scl_in),
        .rise (scl_rise),
        .fall (scl_fall)
    );

    ee2w_shreg #(.W(DATA_W), .CW(CNT_W)) u_shreg (
        .clk   (clk),
        .rst   (rst),
        .ctl   (sh_ctl),
        .din   (sda_in),
        .pdata (mem_rdata[DATA_W-2:0]),
        .q     (sh_q),
        .cnt   (bit_cnt)
    );

    ee2w_addr_ctr #(.AW(ADDR_W), .PW(PAGE_W), .DW(DATA_W), .HW(HI_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .ctl  (ad_ctl),
        .hi   (rx_byte[HI_W:1]),
        .lo   (rx_byte),
        .addr (addr_q)
    );

    ee2w_fsm #(.AW(ADDR_W), .DW(DATA_W), .CW(CNT_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .rise    (scl_rise),
        .fall    (scl_fall),
        .start   (start_strb),
        .stop    (stop_strb),
        .sda     (sda_in),
        .busy    (commit_busy),
        .cnt     (bit_cnt),
        .rx_byte (rx_byte),
        .tx_next (sh_q[DATA_W-2]),
        .mem_msb (mem_rdata[DATA_W-1]),
        .addr    (addr_q),
        .sh      (sh_ctl),
        .ad      (ad_ctl),
        .pull    (sda_pull),
        .wb_we   (wbuf_we),
        .wb_addr (wbuf_addr),
        .wb_data (wbuf_data),
        .commit  (commit_go)
    );
endmodule

// File: rtl/ee2w_slave_chk.sv
module ee2w_slave_chk (
    input logic clk,
    input logic rst,
    input logic scl_in,
    input logic start_strb,
    input logic stop_strb,
    input logic commit_busy,
    input logic sda_pull,
    input logic wbuf_we,
    input logic commit_go
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_pull && !wbuf_we && !commit_go));

    a_r3_pull_on_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> (!$past(scl_in) && $past(scl_in, 2)));

    a_r3_steady_high: assert property (@(posedge clk) disable iff (rst)
        ($past(scl_in) && !$past(start_strb) && !$past(stop_strb)) |-> $stable(sda_pull));

    a_r5_we_after_rise: assert property (@(posedge clk) disable iff (rst)
        wbuf_we |-> ($past(scl_in) && !$past(scl_in, 2)));

    a_r7_busy_silent: assert property (@(posedge clk) disable iff (rst)
        (commit_busy && $past(commit_busy) && !$past(sda_pull)) |-> !sda_pull);

    a_r8_commit_on_stop: assert property (@(posedge clk) disable iff (rst)
        commit_go |-> $past(stop_strb));
endmodule

bind ee2w_slave ee2w_slave_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .scl_in      (scl_in),
    .start_strb  (start_strb),
    .stop_strb   (stop_strb),
    .commit_busy (commit_busy),
    .sda_pull    (sda_pull),
    .wbuf_we     (wbuf_we),
    .commit_go   (commit_go)
);

// File: tb/ee2w_slave_test.sv
module ee2w_slave_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        start_strb = 1'b0;
    logic        stop_strb = 1'b0;
    logic        commit_busy = 1'b0;
    logic        sda_in;
    logic [7:0]  mem_rdata;
    logic        sda_pull;
    logic [10:0] mem_raddr;
    logic        wbuf_we;
    logic [10:0] wbuf_addr;
    logic [7:0]  wbuf_data;
    logic        commit_go;

    logic [7:0]  mem [2048];
    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int commit_cnt = 0;

    always #5 clk = ~clk;

    assign sda_in    = sda_m & ~sda_pull;
    assign mem_rdata = mem[mem_raddr];

    ee2w_slave uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_in),
        .start_strb(start_strb), .stop_strb(stop_strb), .commit_busy(commit_busy),
        .mem_rdata(mem_rdata), .sda_pull(sda_pull), .mem_raddr(mem_raddr),
        .wbuf_we(wbuf_we), .wbuf_addr(wbuf_addr), .wbuf_data(wbuf_data),
        .commit_go(commit_go)
    );

    // page buffer and commit model
    always @(posedge clk) begin
        if (wbuf_we) begin
            mem[wbuf_addr] = wbuf_data;
            wr_cnt = wr_cnt + 1;
        end
        if (commit_go) commit_cnt = commit_cnt + 1;
    end

    // {expected ack, device byte}
    localparam logic [8:0] DEV_TAB [8] = '{9'h1A0, 9'h1A1, 9'h0B0, 9'h020,
                                           9'h1AE, 9'h050, 9'h1A9, 9'h0E0};

    function automatic logic [7:0] pat(input int a);
        return 8'(a * 29 + 7);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; tick(2);
        scl = 1'b1; tick(2);
        sda_m = 1'b0; start_strb = 1'b1; tick(1);
        start_strb = 1'b0; tick(2);
        scl = 1'b0; tick(2);
    endtask

    task automatic do_stop();
        scl = 1'b0; sda_m = 1'b0; tick(2);
        scl = 1'b1; tick(2);
        sda_m = 1'b1; stop_strb = 1'b1; tick(1);
        stop_strb = 1'b0; tick(2);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b; tick(3);
        scl = 1'b1; tick(2);
        s = sda_in; tick(2);
        scl = 1'b0; tick(3);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] v;
        int         c0, w0;
        for (int i = 0; i < 2048; i++) mem[i] = pat(i);
        tick(4);
        // R1 reset state
        check(!sda_pull && !wbuf_we && !commit_go, "R1 outputs idle in reset", int'(sda_pull), 0);
        rst = 1'b0;
        tick(1);
        check(!sda_pull && !wbuf_we && !commit_go, "R1 outputs idle after reset", int'(wbuf_we), 0);
        check(mem_raddr == 11'd0, "R1 address zero", int'(mem_raddr), 0);
        tick(4);

        // R2 R4 device byte decode table
        for (int i = 0; i < 8; i++) begin
            c0 = commit_cnt;
            do_start();
            send_byte(DEV_TAB[i][7:0], ack);
            check(ack == DEV_TAB[i][8], "R2 device tag decode", int'(ack), int'(DEV_TAB[i][8]));
            do_stop();
            check(commit_cnt == c0, "R8 no commit without data", commit_cnt - c0, 0);
        end

        // R2 rest of rejected transfer ignored
        do_start();
        send_byte(8'hC0, ack);
        send_byte(8'h00, ack);
        check(!ack && !sda_pull, "R2 ignored after bad tag", int'(ack), 0);
        do_stop();

        // R3 R5 R8 byte write at 0x235
        c0 = commit_cnt; w0 = wr_cnt;
        do_start();
        send_byte(8'hA4, ack);
        check(ack, "R3 ack device byte", int'(ack), 1);
        check(!sda_pull, "R3 ack released after ninth clock", int'(sda_pull), 0);
        send_byte(8'h35, ack);
        check(ack, "R5 ack address byte", int'(ack), 1);
        send_byte(8'h5A, ack);
        check(ack, "R5 ack data byte", int'(ack), 1);
        do_stop();
        check(wr_cnt - w0 == 1, "R5 one buffer write", wr_cnt - w0, 1);
        check(mem[11'h235] == 8'h5A, "R5 data at 0x235", int'(mem[11'h235]), 'h5A);
        check(commit_cnt - c0 == 1, "R8 commit after write", commit_cnt - c0, 1);

        // R7 busy blocks acknowledge
        commit_busy = 1'b1;
        do_start();
        send_byte(8'hA0, ack);
        check(!ack && !sda_pull, "R7 no ack while busy", int'(ack), 0);
        do_stop();
        commit_busy = 1'b0;
        tick(2);

        // R6 page wrap 0x33E 0x33F 0x330
        c0 = commit_cnt; w0 = wr_cnt;
        do_start();
        send_byte(8'hA6, ack);
        send_byte(8'h3E, ack);
        send_byte(8'h11, ack);
        send_byte(8'h22, ack);
        send_byte(8'h33, ack);
        check(ack, "R5 ack third data byte", int'(ack), 1);
        do_stop();
        check(wr_cnt - w0 == 3, "R6 three buffer writes", wr_cnt - w0, 3);
        check(mem[11'h33E] == 8'h11, "R6 byte 0x33E", int'(mem[11'h33E]), 'h11);
        check(mem[11'h33F] == 8'h22, "R6 byte 0x33F", int'(mem[11'h33F]), 'h22);
        check(mem[11'h330] == 8'h33, "R6 wrap to 0x330", int'(mem[11'h330]), 'h33);
        check(mem[11'h340] == pat('h340), "R6 next page untouched", int'(mem[11'h340]), int'(pat('h340)));
        check(commit_cnt - c0 == 1, "R8 commit after page", commit_cnt - c0, 1);

        // R8 stop after address only
        c0 = commit_cnt;
        do_start();
        send_byte(8'hA0, ack);
        send_byte(8'h10, ack);
        do_stop();
        check(commit_cnt == c0, "R8 no commit after address only", commit_cnt - c0, 0);

        // R9 R4 random read from 0x235 then 0x236
        c0 = commit_cnt;
        do_start();
        send_byte(8'hA4, ack);
        send_byte(8'h35, ack);
        do_start();
        send_byte(8'hA5, ack);
        check(ack, "R4 read device byte ack", int'(ack), 1);
        read_byte(1'b1, v);
        check(v == 8'h5A, "R9 read 0x235", int'(v), 'h5A);
        read_byte(1'b0, v);
        check(v == pat('h236), "R9 read next 0x236", int'(v), int'(pat('h236)));
        clk_bit(1'b1, ack);
        check(ack && !sda_pull, "R9 released after master nack", int'(sda_pull), 0);
        do_stop();
        check(commit_cnt == c0, "R10 restart leaves no commit", commit_cnt - c0, 0);

        // R9 linear wrap 0x7FF -> 0x000
        do_start();
        send_byte(8'hAE, ack);
        send_byte(8'hFF, ack);
        do_start();
        send_byte(8'hAF, ack);
        read_byte(1'b1, v);
        check(v == pat('h7FF), "R9 read 0x7FF", int'(v), int'(pat('h7FF)));
        read_byte(1'b0, v);
        check(v == pat(0), "R9 wrap to 0x000", int'(v), int'(pat(0)));
        do_stop();

        // R10 start in the middle of a data byte
        c0 = commit_cnt; w0 = wr_cnt;
        do_start();
        send_byte(8'hA0, ack);
        send_byte(8'h10, ack);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, ack);
        do_start();
        send_byte(8'hA0, ack);
        check(ack, "R10 new device byte after restart", int'(ack), 1);
        send_byte(8'h20, ack);
        do_stop();
        check(wr_cnt == w0, "R10 no buffer write from aborted byte", wr_cnt - w0, 0);
        check(commit_cnt == c0, "R10 no commit after abort", commit_cnt - c0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule